// File: doc/BRIEF.md
# Card-Side Multiple-Block Read Controller

This block is the card side of a multiple-block read on an SD/MMC style card. A command front end passes in decoded commands as an index and a 32-bit argument. The controller answers each command with a one-cycle response that carries status flags. After a read command it fetches bytes from a simple memory port and streams them to a data-line serializer. Each block is followed by its 16-bit checksum.

A read runs in one of two modes. In preset mode it sends a block count loaded in advance and then returns to the transfer state by itself. In open-ended mode it runs until the host sends a stop command. When a fault is detected during the read (a failed memory read, a block reaching past the end of memory, or a misaligned partial block), output freezes and the card stays in the data state. The fault is held in sticky status bits that are reported in the response to the stop command. A stop command sent while no read is running is answered as illegal.

Top module: `mblk_read_ctrl`

## Requirements
- R1: After reset the card is in the transfer state (`card_in_data`=0). `dout_valid`, `mem_rd_en` and `resp_valid` are low, the block length is 512 and no block count is pending.
- R2: Command 16 sets the block length to its argument. The argument is accepted when it lies between 1 and 512 and either `part_en` is high or it equals 512. Any other value is answered with status bit 3 (illegal) and leaves the length unchanged.
- R3: Command 18 with argument A enters the data state. Blocks are then read from consecutive addresses starting at A, and each block starts at the previous block's address plus the block length. A byte read in one cycle appears on `dout_byte` with `dout_valid` high in the next cycle, with `dout_crc` low.
- R4: After the data bytes of a block, two bytes with `dout_crc` high carry the checksum, high byte first. The checksum is CRC-16 with polynomial 0x1021 and initial value 0, computed MSB first over the block's data bytes.
- R5: Command 23 loads a block count from argument bits 15:0. The next command 18 uses this count and clears it. With a nonzero count the card returns to the transfer state after the last checksum byte of the final block. A count of zero selects open-ended mode.
- R6: In the data state, a stop command (index 12) ends output after its own cycle and returns the card to the transfer state.
- R7: A stop command outside the data state is answered with status bit 3. In the data state, any command other than stop is answered with status bit 3 and has no effect on the stream.
- R8: If `mem_err` is high with a read byte, that byte is not output. The card moves to the halted data state and latches status bit 2.
- R9: At the start of a block whose last byte would lie at or beyond MEM_BYTES, no byte is read. The card halts and latches status bit 0.
- R10: When `part_en` is high and `misalign_en` low, a block that would cross a 512-byte boundary is detected at its start. The card halts and latches status bit 1. Blocks before it are sent in full.
- R11: In the halted state no memory reads and no output occur, and only a stop command leaves it.
- R12: A response follows each command by one cycle. Latched fault bits 2:0 appear only in the response to a stop command given in the data state, and are cleared once reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| part_en | input | 1 | Partial block lengths allowed |
| misalign_en | input | 1 | Blocks may cross a 512-byte boundary |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_valid | output | 1 | Response present |
| resp_status | output | 4 | {illegal, internal, misaligned, out of range} |
| card_in_data | output | 1 | Card is in the data state (sending or halted) |
| mem_rd_en | output | 1 | Memory byte read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd_data | input | 8 | Read byte, one cycle after request |
| mem_err | input | 1 | Read fault, valid with `mem_rd_data` |
| dout_valid | output | 1 | Byte for the serializer |
| dout_byte | output | 8 | Data or checksum byte |
| dout_crc | output | 1 | Current byte is a checksum byte |

## Verification
On every cycle the assertions check the following: the halted state is left only through a stop command; a read request produces an output byte or a fault in the next cycle; a response follows a command; and a bad block start leads to the halted state with the matching bit latched. The bench's scenarios cover the behaviours that need a whole transfer to show. These are the exact byte and checksum stream for preset and open-ended reads, the count being used up after one read, the end of the stream at a stop, and the content and clearing of the stop response after each kind of fault.

// File: rtl/mblk_read_ctrl.sv
module mblk_read_ctrl #(
  parameter int ADDR_W    = 24,
  parameter int MEM_BYTES = 65536,
  parameter int MAX_BLEN  = 512,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              part_en,
  input  logic              misalign_en,
  input  logic              cmd_valid,
  input  logic [5:0]        cmd_idx,
  input  logic [31:0]       cmd_arg,
  output logic              resp_valid,
  output logic [3:0]        resp_status,
  output logic              card_in_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  input  logic              mem_err,
  output logic              dout_valid,
  output logic [7:0]        dout_byte,
  output logic              dout_crc
);
  localparam int LEN_W = $clog2(MAX_BLEN + 1);
  localparam int OFS_W = $clog2(MAX_BLEN);
  localparam logic [5:0] C_STOP = 6'd12, C_BLEN = 6'd16, C_READ = 6'd18, C_BCNT = 6'd23;

  typedef enum logic [1:0] {XFER, SEND, HALT} st_t;
  typedef enum logic [1:0] {PH_DATA, PH_DRAIN, PH_CRCH, PH_CRCL} ph_t;

  st_t st;
  ph_t ph;
  logic [LEN_W-1:0]  blen, bcnt;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  preset, left;
  logic              open_end, rd_pend;
  logic [15:0]       crc;
  logic [2:0]        sticky;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ d[i]) ? 16'h1021 : 16'h0000);
    return r;
  endfunction

  wire is_stop   = cmd_valid && cmd_idx == C_STOP;
  wire blk_start = st == SEND && ph == PH_DATA && bcnt == '0;
  wire [ADDR_W:0] end_addr = {1'b0, addr} + (ADDR_W+1)'(blen);
  wire oor       = end_addr > (ADDR_W+1)'(MEM_BYTES);
  wire [OFS_W:0] ofs_end = {1'b0, addr[OFS_W-1:0]} + (OFS_W+1)'(blen);
  wire misal     = part_en && !misalign_en && ofs_end > (OFS_W+1)'(MAX_BLEN);
  wire bad_start = blk_start && (oor || misal);
  wire rd_fail   = st == SEND && rd_pend && mem_err;
  wire len_ok    = cmd_arg >= 32'd1 && cmd_arg <= 32'(MAX_BLEN) &&
                   (part_en || cmd_arg == 32'(MAX_BLEN));
  wire xfer_ok   = (cmd_idx == C_BLEN && len_ok) || cmd_idx == C_BCNT || cmd_idx == C_READ;
  wire illegal   = cmd_valid && (st == XFER ? !xfer_ok : cmd_idx != C_STOP);
  wire [2:0] new_err = {rd_fail, bad_start && misal, bad_start && oor};
  wire report    = is_stop && st != XFER;
  wire crc_ph    = st == SEND && (ph == PH_CRCH || ph == PH_CRCL);

  assign card_in_data = st != XFER;
  assign mem_rd_en    = st == SEND && ph == PH_DATA && !bad_start && !rd_fail;
  assign mem_addr     = addr + ADDR_W'(bcnt);
  assign dout_valid   = (rd_pend && !mem_err) || crc_ph;
  assign dout_crc     = !rd_pend && crc_ph;
  assign dout_byte    = rd_pend ? mem_rd_data : (ph == PH_CRCH ? crc[15:8] : crc[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= XFER; ph <= PH_DATA; blen <= LEN_W'(MAX_BLEN); bcnt <= '0;
      addr <= '0; preset <= '0; left <= '0; open_end <= 1'b0; rd_pend <= 1'b0;
      crc <= '0; sticky <= '0; resp_valid <= 1'b0; resp_status <= '0;
    end else begin
      resp_valid  <= cmd_valid;
      resp_status <= cmd_valid ? {illegal, report ? (sticky | new_err) : 3'b000} : 4'b0;
      sticky      <= report ? 3'b000 : (sticky | new_err);
      rd_pend     <= mem_rd_en;
      if (rd_pend && !mem_err) crc <= crc_step(crc, mem_rd_data);
      case (st)
        XFER: if (cmd_valid) begin
          if (cmd_idx == C_BLEN && len_ok) blen <= LEN_W'(cmd_arg);
          if (cmd_idx == C_BCNT) preset <= cmd_arg[CNT_W-1:0];
          if (cmd_idx == C_READ) begin
            st <= SEND; ph <= PH_DATA; bcnt <= '0; addr <= cmd_arg[ADDR_W-1:0];
            left <= preset; open_end <= preset == '0; preset <= '0; crc <= '0;
          end
        end
        SEND:
          if (is_stop) begin
            st <= XFER; rd_pend <= 1'b0;
          end else if (rd_fail || bad_start) begin
            st <= HALT; rd_pend <= 1'b0;
          end else begin
            case (ph)
              PH_DATA:
                if (bcnt == blen - 1'b1) begin ph <= PH_DRAIN; bcnt <= '0; end
                else bcnt <= bcnt + 1'b1;
              PH_DRAIN: ph <= PH_CRCH;
              PH_CRCH:  ph <= PH_CRCL;
              default: begin
                crc <= '0;
                ph  <= PH_DATA;
                if (!open_end && left == CNT_W'(1)) st <= XFER;
                else begin
                  left <= left - 1'b1;
                  addr <= addr + ADDR_W'(blen);
                end
              end
            endcase
          end
        default: if (is_stop) st <= XFER;
      endcase
    end
  end

  assert_halt_only_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HALT && !is_stop) |=> st == HALT);
  assert_read_yields_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !is_stop) |=> (dout_valid || mem_err));
  assert_resp_follows_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(cmd_valid));
  assert_fault_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fail && !is_stop) |=> (st == HALT && sticky[2]));
  assert_range_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && oor && !is_stop) |=> (st == HALT && sticky[0]));
  assert_misalign_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && misal && !is_stop) |=> (st == HALT && sticky[1]));
endmodule

// File: tb/mblk_read_ctrl_bench.sv
module mblk_read_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int AW = 24;

  logic clk = 0, rst_n = 0, part_en = 1, misalign_en = 1;
  logic cmd_valid = 0;
  logic [5:0] cmd_idx = 0;
  logic [31:0] cmd_arg = 0;
  logic resp_valid, card_in_data, mem_rd_en, dout_valid, dout_crc;
  logic [3:0] resp_status;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rd_data, dout_byte;
  logic mem_err;

  int tests = 0, fails = 0, popped = 0;
  logic [7:0] qb[$];
  logic       qc[$];
  logic [AW-1:0] raddr = 0, err_addr = '1;
  logic rv = 0;

  always #(PERIOD/2) clk = ~clk;

  mblk_read_ctrl #(.ADDR_W(AW), .MEM_BYTES(4096)) u_mblk_read_ctrl (
    .clk, .rst_n, .part_en, .misalign_en, .cmd_valid, .cmd_idx, .cmd_arg,
    .resp_valid, .resp_status, .card_in_data, .mem_rd_en, .mem_addr,
    .mem_rd_data, .mem_err, .dout_valid, .dout_byte, .dout_crc);

  function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
    return 8'((a * 13) + (a >> 8) + 5);
  endfunction

  always @(posedge clk) begin
    rv <= mem_rd_en;
    if (mem_rd_en) raddr <= mem_addr;
  end
  assign mem_rd_data = mbyte(raddr);
  assign mem_err = rv && raddr == err_addr;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && dout_valid) begin
    if (qb.size() == 0) check(0, "R3/R6/R11 unexpected output byte", dout_byte, 0);
    else begin
      logic [7:0] eb; logic ec;
      eb = qb.pop_front(); ec = qc.pop_front(); popped++;
      check(dout_byte == eb && dout_crc == ec, "R3/R4 stream byte",
            {dout_crc, dout_byte}, {ec, eb});
    end
  end

  task automatic push_blocks(input int start, input int len, input int n);
    for (int b = 0; b < n; b++) begin
      logic [15:0] c;
      c = 0;
      for (int i = 0; i < len; i++) begin
        logic [7:0] d;
        d = mbyte(AW'(start + b*len + i));
        qb.push_back(d); qc.push_back(0);
        for (int k = 7; k >= 0; k--) c = {c[14:0], 1'b0} ^ ((c[15] ^ d[k]) ? 16'h1021 : 16'h0);
      end
      qb.push_back(c[15:8]); qc.push_back(1);
      qb.push_back(c[7:0]);  qc.push_back(1);
    end
  endtask

  task automatic cmd(input int idx, input int arg, input logic [3:0] exp, input string tag);
    @(negedge clk);
    cmd_valid = 1; cmd_idx = 6'(idx); cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 0;
    check(resp_valid && resp_status == exp, tag, {resp_valid, resp_status}, {1'b1, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(2);
    check(!card_in_data && !dout_valid && !mem_rd_en && !resp_valid, "R1 reset outputs",
          {card_in_data, dout_valid, mem_rd_en, resp_valid}, 0);
    rst_n = 1;
    idle(2);
    // R1: default length 512 is legal with partial blocks off
    part_en = 0;
    cmd(16, 8, 4'b1000, "R2 partial length refused");
    cmd(16, 512, 4'b0000, "R2 full length accepted");
    part_en = 1;
    cmd(16, 0, 4'b1000, "R2 zero length refused");
    cmd(16, 513, 4'b1000, "R2 oversize refused");
    cmd(16, 8, 4'b0000, "R2 length 8");

    // R5 preset count of three
    cmd(23, 3, 4'b0000, "R5 load count");
    push_blocks(100, 8, 3);
    cmd(18, 100, 4'b0000, "R3 start read");
    check(card_in_data, "R3 in data state", card_in_data, 1);
    idle(45);
    check(qb.size() == 0, "R5 all preset blocks sent", qb.size(), 0);
    check(!card_in_data, "R5 back to transfer", card_in_data, 0);
    cmd(12, 0, 4'b1000, "R7 stop after last block illegal");

    // R5 count used up -> open-ended, R6 stop, R7 other command ignored
    push_blocks(0, 8, 20);
    popped = 0;
    cmd(18, 0, 4'b0000, "R5 open-ended start");
    idle(15);
    cmd(16, 4, 4'b1000, "R7 command in data state illegal");
    idle(15);
    check(card_in_data, "R6 open-ended still running", card_in_data, 1);
    cmd(12, 0, 4'b0000, "R6 stop response clean");
    qb.delete(); qc.delete();
    check(popped >= 30 && !card_in_data, "R6 stopped after stream", popped, 30);
    idle(10);

    // R8 memory fault on byte 203
    err_addr = 203;
    cmd(23, 2, 4'b0000, "R8 count");
    push_blocks(0, 0, 0);
    qb.push_back(mbyte(200)); qc.push_back(0);
    qb.push_back(mbyte(201)); qc.push_back(0);
    qb.push_back(mbyte(202)); qc.push_back(0);
    cmd(18, 200, 4'b0000, "R8 start");
    idle(20);
    check(card_in_data && qb.size() == 0, "R8 halted in data state", {card_in_data, 8'(qb.size())}, 9'h100);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!mem_rd_en && !dout_valid, "R11 quiet while halted", {mem_rd_en, dout_valid}, 0);
    end
    cmd(16, 8, 4'b1000, "R11 non-stop in halt illegal");
    check(card_in_data, "R11 still halted", card_in_data, 1);
    cmd(12, 0, 4'b0100, "R12 stop reports internal fault");
    check(!card_in_data, "R12 stop leaves halt", card_in_data, 0);
    cmd(12, 0, 4'b1000, "R12 fault bits cleared");
    err_addr = '1;

    // R9 out of range at 4096
    push_blocks(4080, 8, 2);
    cmd(18, 4080, 4'b0000, "R9 start");
    idle(40);
    check(card_in_data && qb.size() == 0, "R9 halted after two blocks", {card_in_data, 8'(qb.size())}, 9'h100);
    cmd(12, 0, 4'b0001, "R9 stop reports range");

    // R10 misaligned third block
    misalign_en = 0;
    cmd(16, 200, 4'b0000, "R10 length 200");
    push_blocks(0, 200, 2);
    cmd(18, 0, 4'b0000, "R10 start");
    idle(450);
    check(card_in_data && qb.size() == 0, "R10 halted at block 400", {card_in_data, 8'(qb.size())}, 9'h100);
    cmd(12, 0, 4'b0010, "R10 stop reports misalignment");
    misalign_en = 1;
    cmd(23, 3, 4'b0000, "R10 count");
    push_blocks(0, 200, 3);
    cmd(18, 0, 4'b0000, "R10 crossing allowed");
    idle(650);
    check(!card_in_data && qb.size() == 0, "R10 three blocks sent", {card_in_data, 8'(qb.size())}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule